// File: doc/BRIEF.md
# Polyphase FIR Decimator

This block lowers the sample rate of a signed fixed-point stream by an integer factor. Samples enter at the fast rate, qualified by a valid strobe, and one filtered sample leaves for every `DECIM` accepted inputs. The anti-alias filter is never evaluated at full rate. Each accepted input belongs to one of `DECIM` phases in rotation. For that phase, a small bank of multipliers forms a partial sum of `TAPS/DECIM` products, using coefficients chosen by the phase. An accumulator collects the partial sums of one block of `DECIM` samples. At the end of the block it releases the total, rounded and saturated.

The result is identical to running the full `TAPS`-long FIR at the input rate and keeping only the output that falls on the last sample of each block. Block alignment is fixed by reset: the first block consists of the first `DECIM` samples accepted after reset, and the filter history starts at zero. The valid strobe may drop for any number of cycles. Idle cycles leave the filter state untouched.

Coefficients are a fixed parameter in signed Q1.(COEF_W-1) format. Defaults: `DECIM` = 4, 16 taps, 16-bit data and coefficients.

Top module: `poly_decim`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its sample history, block position and accumulator, and drives `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` rises for exactly one cycle, in the cycle after the clock edge that accepts the `DECIM`-th, 2·`DECIM`-th, … sample since reset. It is never high at any other time.
- R3: Each output equals round(y[n] / 2^15) with n = `DECIM`·b + `DECIM` − 1 (n counts accepted samples from 0). Here y[n] = Σ h[k]·x[n−k] for k = 0..`TAPS`−1, and samples before reset count as zero.
- R4: A cycle with `in_valid` = 0 leaves history, block position and accumulator unchanged. A stream with idle gaps therefore yields the same outputs as the same stream without gaps.
- R5: Rounding is to nearest, with exact halves toward +∞: out = floor((y + 2^14) / 2^15). For example, y = 16384 gives 1 and y = −16384 gives 0.
- R6: A rounded result above 32767 is output as 32767. A rounded result below −32768 is output as −32768.
- R7: Coefficient h[k] is the signed 16-bit field at bits [16k+15 : 16k] of parameter `COEFS` (bit 15 is the sign, 15 fraction bits).
- R8: `out_data` keeps its value in every cycle in which `out_valid` is low.
- R9: A reset in the middle of a block discards the partial block. The next output comes after `DECIM` further accepted samples and uses only post-reset data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a new output sample |
| out_data | output | DATA_W | Signed decimated, rounded and saturated output |

## Verification
Phase-counter errors show at the ports as soon as the next block would end. In that case `out_valid` appears after the wrong number of accepted samples, which the bench flags as an unexpected or missing output within `DECIM` samples. A corrupted history word or coefficient selection changes a single partial product. It surfaces in the very next output as a value that differs from the full-rate reference. A mis-cleared accumulator carries a stale sum into the next block, so the first output after the fault is already wrong. Damage to the delay line persists for up to `TAPS` samples and can appear in several consecutive outputs.

// File: rtl/poly_decim_pkg.sv
// Shared helpers for the polyphase decimator.
// Assumes phases are numbered 0..decim-1 in arrival order within a block.
package poly_decim_pkg;

    // Tap index used by multiplier slot 'slot' while serving phase 'phase'.
    // A sample at block position p lies (decim-1-p) samples before the block's
    // output instant; each later slot reaches back one more whole block.
    function automatic int coef_index(input int phase, input int slot, input int decim);
        return (decim - 1 - phase) + slot * decim;
    endfunction

endpackage

// File: rtl/poly_decim_phase.sv
// Phase counter: counts accepted samples modulo DECIM.
// Assumes adv is high only in cycles that carry a sample.
module poly_decim_phase #(
    parameter int DECIM = 4,
    localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [PH_W-1:0] phase,
    output logic            first,
    output logic            last
);

    assign first = (phase == '0);
    assign last  = (phase == PH_W'(DECIM - 1));

    // Step the phase on each accepted sample, wrapping after the block's last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (adv)
            phase <= last ? '0 : phase + 1'b1;
    end

endmodule

// File: rtl/poly_decim_tapline.sv
// Sample history: a shift register of past inputs, tapped every DECIM samples.
// taps[0] is the sample being accepted now; taps[j] is the one j*DECIM earlier.
// Assumes SLOTS >= 1; the history shifts only on accepted samples.
module poly_decim_tapline #(
    parameter int DATA_W = 16,
    parameter int DECIM  = 4,
    parameter int SLOTS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift,
    input  logic signed [DATA_W-1:0] din,
    output logic signed [DATA_W-1:0] taps [SLOTS]
);

    localparam int LEN = (SLOTS - 1) * DECIM;

    assign taps[0] = din;

    generate
        if (LEN > 0) begin : g_hist
            logic signed [DATA_W-1:0] hist [LEN];

            // Push the accepted sample in and age the others by one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < LEN; i++) hist[i] <= '0;
                end else if (shift) begin
                    hist[0] <= din;
                    for (int i = 1; i < LEN; i++) hist[i] <= hist[i-1];
                end
            end

            for (genvar j = 1; j < SLOTS; j++) begin : g_tap
                assign taps[j] = hist[j*DECIM - 1];
            end
        end
    endgenerate

endmodule

// File: rtl/poly_decim_mac.sv
// Multiplier bank: SLOTS signed products with per-phase coefficient selection,
// summed into one full-precision partial result. Purely combinational.
// Assumes COEFS packs tap k at bits [k*COEF_W +: COEF_W].
module poly_decim_mac
    import poly_decim_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int DECIM  = 4,
    parameter int SLOTS  = 4,
    parameter int ACC_W  = 36,
    parameter logic [SLOTS*DECIM*COEF_W-1:0] COEFS = '0,
    localparam int PH_W   = (DECIM > 1) ? $clog2(DECIM) : 1,
    localparam int PROD_W = DATA_W + COEF_W
) (
    input  logic        [PH_W-1:0]   phase,
    input  logic signed [DATA_W-1:0] taps [SLOTS],
    output logic signed [ACC_W-1:0]  partial
);

    logic signed [PROD_W-1:0] prod [SLOTS];

    generate
        for (genvar j = 0; j < SLOTS; j++) begin : g_slot
            logic signed [COEF_W-1:0] coef;

            // Pick this slot's coefficient for the current phase.
            always_comb coef = COEFS[coef_index(int'(phase), j, DECIM)*COEF_W +: COEF_W];

            assign prod[j] = coef * taps[j];
        end
    endgenerate

    // Add the sign-extended products of all slots.
    always_comb begin
        partial = '0;
        for (int j = 0; j < SLOTS; j++) partial = partial + ACC_W'(prod[j]);
    end

endmodule

// File: rtl/poly_decim_acc.sv
// Block accumulator with output stage: loads on a block's first sample, adds on
// the rest, and on the last sample rounds (half toward +inf) and saturates the total.
// Assumes FRAC >= 1 and ACC_W large enough for the full tap count.
module poly_decim_acc #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 36,
    parameter int FRAC   = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept,
    input  logic                     first,
    input  logic                     last,
    input  logic signed [ACC_W-1:0]  partial,
    output logic signed [ACC_W-1:0]  acc_q,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'(2**(DATA_W-1) - 1);
    localparam logic signed [ACC_W:0] MINV = -(ACC_W+1)'(2**(DATA_W-1));

    logic signed [ACC_W-1:0]  total;
    logic signed [ACC_W:0]    biased;
    logic signed [ACC_W:0]    shifted;
    logic signed [DATA_W-1:0] sat;

    // Running block sum including the sample being accepted.
    always_comb total = first ? partial : acc_q + partial;

    // Round to nearest and clamp to the output range.
    always_comb begin
        biased  = {total[ACC_W-1], total} + HALF;
        shifted = biased >>> FRAC;
        if (shifted > MAXV)
            sat = MAXV[DATA_W-1:0];
        else if (shifted < MINV)
            sat = MINV[DATA_W-1:0];
        else
            sat = shifted[DATA_W-1:0];
    end

    // Update the accumulator per sample and release the result at block end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= accept && last;
            if (accept)
                acc_q <= total;
            if (accept && last)
                out_data <= sat;
        end
    end

endmodule

// File: rtl/poly_decim.sv
// Polyphase FIR decimator top: one output per DECIM accepted inputs, equal to
// the full-rate FIR sampled on each block's last input.
// Assumes TAPS is a multiple of DECIM and coefficients are signed Q1.(COEF_W-1).
module poly_decim #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int DECIM  = 4,
    parameter int TAPS   = 16,
    parameter logic [TAPS*COEF_W-1:0] COEFS = {
        16'hFF00, 16'hFE00, 16'h0000, 16'h0600, 16'h0E00, 16'h1800, 16'h2000, 16'h2400,
        16'h2400, 16'h2000, 16'h1800, 16'h0E00, 16'h0600, 16'h0000, 16'hFE00, 16'hFF00
    },
    localparam int SLOTS = TAPS / DECIM,
    localparam int PH_W  = (DECIM > 1) ? $clog2(DECIM) : 1,
    localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    logic [PH_W-1:0]          phase_q;
    logic                     blk_first;
    logic                     blk_last;
    logic signed [DATA_W-1:0] taps [SLOTS];
    logic signed [ACC_W-1:0]  partial;
    logic signed [ACC_W-1:0]  acc_q;

    poly_decim_phase #(.DECIM(DECIM)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (in_valid),
        .phase (phase_q),
        .first (blk_first),
        .last  (blk_last)
    );

    poly_decim_tapline #(.DATA_W(DATA_W), .DECIM(DECIM), .SLOTS(SLOTS)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (in_valid),
        .din   (in_data),
        .taps  (taps)
    );

    poly_decim_mac #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .DECIM  (DECIM),
        .SLOTS  (SLOTS),
        .ACC_W  (ACC_W),
        .COEFS  (COEFS)
    ) u_mac (
        .phase   (phase_q),
        .taps    (taps),
        .partial (partial)
    );

    poly_decim_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC(COEF_W - 1)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (in_valid),
        .first     (blk_first),
        .last      (blk_last),
        .partial   (partial),
        .acc_q     (acc_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/poly_decim_chk.sv
// Protocol and state checks for poly_decim, attached by bind.
module poly_decim_chk #(
    parameter int DECIM  = 4,
    parameter int DATA_W = 16,
    parameter int PH_W   = 2,
    parameter int ACC_W  = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [PH_W-1:0]   phase,
    input logic [ACC_W-1:0]  acc
);

    // R2
    block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == PH_W'(DECIM - 1)) |=> out_valid);

    // R2
    no_stray_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && phase == PH_W'(DECIM - 1)));

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && phase == PH_W'(DECIM - 1)) |=> (phase == '0));

    generate
        if (DECIM > 1) begin : g_pulse
            // R2
            single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid);
        end
    endgenerate

    // R4
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase));

    // R4
    idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc));

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_valid) |-> $stable(out_data));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && phase == '0));

endmodule

bind poly_decim poly_decim_chk #(
    .DECIM  (DECIM),
    .DATA_W (DATA_W),
    .PH_W   (PH_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .phase     (phase_q),
    .acc       (acc_q)
);

// File: tb/poly_decim_tb.sv
`timescale 1ns/1ps
module poly_decim_tb;

    localparam int DW  = 16;
    localparam int CW  = 16;
    localparam int DEC = 4;
    localparam int NT  = 16;

    // Bench coefficient set (asymmetric so tap order matters), h[0]..h[15].
    localparam int H [NT] = '{-300, -600, 0, 16384, 3500, 6000, 8000, 9000,
                              7000, 5000, 4000, 2500, 1500, 200, -600, -300};

    // R7: pack h[k] into bits [16k +: 16].
    function automatic logic [NT*CW-1:0] pack_coefs();
        logic [NT*CW-1:0] p;
        p = '0;
        for (int k = 0; k < NT; k++) p[k*CW +: CW] = CW'(H[k]);
        return p;
    endfunction

    // Stimulus table: {sample, idle cycles after it}.
    localparam int NSTIM = 24;
    localparam int STIM [NSTIM][2] = '{
        '{1000, 0}, '{-2000, 0}, '{3000, 1}, '{-4000, 0},
        '{12000, 0}, '{32767, 3}, '{-32768, 0}, '{500, 0},
        '{-7, 2}, '{20000, 0}, '{-20000, 0}, '{1, 0},
        '{30000, 0}, '{30000, 5}, '{30000, 0}, '{30000, 0},
        '{-1234, 0}, '{4321, 1}, '{0, 0}, '{-30000, 0},
        '{-30000, 0}, '{-30000, 2}, '{-30000, 0}, '{777, 0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_data;

    always #2.5 clk = ~clk;

    poly_decim #(.DATA_W(DW), .COEF_W(CW), .DECIM(DEC), .TAPS(NT), .COEFS(pack_coefs())) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int    checks = 0;
    int    fails  = 0;
    int    hist [NT];
    int    cnt = 0;
    int    expq [$];
    int    last_out = 0;
    int    held = 0;
    int    n_out = 0;
    string cur_req = "R3";
    bit    done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference: round half toward +inf, then clamp (R5, R6).
    function automatic int ref_round(input longint s);
        longint r;
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NT; k++) hist[k] = 0;
        cnt = 0;
        expq.delete();
    endtask

    // Drive one sample, update the full-rate reference, then idle 'gap' cycles.
    task automatic send(input int x, input int gap);
        longint s;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'(x);
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        if (cnt % DEC == DEC - 1) begin
            s = 0;
            for (int k = 0; k < NT; k++) s += longint'(H[k]) * longint'(hist[k]);
            expq.push_back(ref_round(s));
        end
        cnt++;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        held  = 0;
    endtask

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                n_out++;
                last_out = int'(out_data);
                held     = int'(out_data);
                if (expq.size() == 0) begin
                    check("R2 unexpected out_valid", 1, 0);
                end else begin
                    check(cur_req, int'(out_data), expq.pop_front());
                end
            end else begin
                check("R8", int'(out_data), held);
            end
        end
    end

    initial begin
        int n0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs cleared while reset is applied.
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_data", int'(out_data), 0);
        rst_n = 1'b1;

        // R3 / R4: table walk with idle gaps, compared with the full-rate reference.
        cur_req = "R3/R4";
        for (int i = 0; i < NSTIM; i++) send(STIM[i][0], STIM[i][1]);
        idle(3);
        check("R2 outputs per block", n_out, NSTIM / DEC);
        check("R2 pending", expq.size(), 0);

        // R5: y = +16384 rounds up to 1.
        do_reset();
        cur_req = "R5";
        send(1, 0); send(0, 0); send(0, 0); send(0, 0);
        idle(2);
        check("R5 half up", last_out, 1);
        // R5: y = -16384 rounds to 0 (ties toward +inf).
        do_reset();
        send(-1, 0); send(0, 0); send(0, 0); send(0, 0);
        idle(2);
        check("R5 neg half", last_out, 0);

        // R6: full-scale DC with coefficient sum above unity saturates.
        do_reset();
        cur_req = "R6";
        for (int i = 0; i < NT; i++) send(32767, 0);
        idle(2);
        check("R6 pos clamp", last_out, 32767);
        for (int i = 0; i < NT; i++) send(-32768, 0);
        idle(2);
        check("R6 neg clamp", last_out, -32768);

        // R4: a long idle stretch mid-block produces nothing and loses nothing.
        do_reset();
        cur_req = "R4";
        n0 = n_out;
        send(5000, 0); send(-3000, 20);
        check("R4 no output while idle", n_out, n0);
        send(7000, 0); send(100, 0);
        idle(2);
        check("R4 block completes", n_out, n0 + 1);

        // R9: reset two samples into a block; next output needs a full new block.
        do_reset();
        send(30000, 0); send(30000, 0);
        do_reset();
        cur_req = "R9";
        n0 = n_out;
        send(1, 0); send(0, 0); send(0, 0);
        idle(2);
        check("R9 no early output", n_out, n0);
        send(0, 0);
        idle(2);
        check("R9 output count", n_out, n0 + 1);
        check("R9 value", last_out, 1);

        // R7 / R3: impulse exposes h[3], h[7], h[11], h[15] in order.
        do_reset();
        cur_req = "R7";
        send(32767, 0);
        for (int i = 1; i < NT; i++) send(0, 0);
        idle(2);
        check("R7 last tap", last_out, ref_round(longint'(H[15]) * 32767));

        idle(3);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule